// File: doc/BRIEF.md
# Debug Link Mode Selector

This block sits on the target side of a combined JTAG / two-wire serial debug port. It watches the single shared data/mode line, sampled once per debug clock edge, and decides which protocol the port should use. Out of power-on reset the port is in JTAG mode. A host moves it to serial-wire mode with a fixed sequence: a line reset, a 16-bit select word sent least-significant bit first, and a second line reset.

A line reset is a run of more than `RESET_MIN - 1` consecutive high samples. A run-length counter tracks the line and saturates once it reaches the threshold. After a line reset, the first low sample starts a 16-bit collection. The collected word is compared against the current select word and, when enabled, against an older alternative. A matching word arms a confirmation phase, and the mode switches only when the trailing line reset completes. A word that does not match is dropped, and the block then waits for the next line reset. Serial-wire mode is sticky until the asynchronous reset is applied.

Top module: `dbg_wire_select`

## Requirements
- R1: `line_reset_o` is 1 in the cycle after the 51st consecutive high sample and stays 1 while the line stays high. It is still 0 after exactly 50 high samples, and it returns to 0 after any low sample.
- R2: After a line reset, the word 0xE79E sent LSB first (the first bit on the line is bit 0, so the low byte 0x9E leads), followed by at least 51 high samples, sets `serial_mode_o` to 1. Encoding: 1 means serial-wire mode and 0 means JTAG mode.
- R3: The older word 0xEDB6, sent LSB first in the same framing, also sets `serial_mode_o` to 1.
- R4: A select word that follows a high run of only 50 samples is ignored, and `serial_mode_o` stays 0.
- R5: A 16-bit word that matches neither pattern (for example 0xE78E) is ignored. The mode is kept and no pulse is produced.
- R6: The mode changes at the clock edge that samples the 51st trailing high bit after the word. After only 50 trailing highs the mode is unchanged.
- R7: `mode_pulse_o` is high for exactly one cycle, in the same cycle that `serial_mode_o` first becomes 1.
- R8: When the port is already in serial-wire mode, repeating the full sequence leaves `serial_mode_o` at 1 and raises no pulse.
- R9: While `rst_n` is low, `serial_mode_o`, `line_reset_o` and `mode_pulse_o` are all 0, independent of the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock; the line is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| line_i | input | 1 | Sampled value of the shared data/mode line |
| serial_mode_o | output | 1 | 1 = serial-wire mode, 0 = JTAG mode |
| line_reset_o | output | 1 | A line reset run is in progress and complete |
| mode_pulse_o | output | 1 | One-cycle pulse when the mode changes |

## Verification
The bench builds the block with its default parameters: a 51-sample reset threshold, the 16-bit words 0xE79E and 0xEDB6, and the older word enabled. With these values the 50/51 boundary can be tested exactly. That boundary matters both for the leading line reset and for the trailing one. The defaults also allow both accepted words and a one-bit near-miss to be driven within a few hundred cycles each. A reset taken in the middle of the run returns the port to JTAG mode, so the older word can be tested from a clean JTAG start.

// File: rtl/dbgsel_pkg.sv
package dbgsel_pkg;

  typedef enum logic [1:0] {
    ST_HUNT,     // waiting for a line reset
    ST_ARMED,    // line reset seen, waiting for first select bit
    ST_COLLECT,  // gathering select word bits
    ST_CONFIRM   // word matched, waiting for trailing line reset
  } sel_state_t;

  // Next value of a saturating high-run counter.
  function automatic logic [15:0] run_next(input logic [15:0] cur,
                                           input logic        hi,
                                           input logic        clr,
                                           input logic [15:0] cap);
    if (!hi || clr) return 16'd0;
    if (cur < cap)  return cur + 16'd1;
    return cur;
  endfunction

  // LSB-first shift: newest bit enters at the top.
  function automatic logic [63:0] lsb_first_shift(input logic [63:0] cur,
                                                  input logic        bit_in,
                                                  input int unsigned w);
    logic [63:0] r;
    r = cur >> 1;
    r[w-1] = bit_in;
    return r;
  endfunction

endpackage

// File: rtl/run_counter.sv
module run_counter #(
  parameter int unsigned RUN_MIN = 51,
  localparam int unsigned CW = $clog2(RUN_MIN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic clr_i,
  output logic reach_o,
  output logic seen_o
);
  import dbgsel_pkg::*;

  logic [CW-1:0] cnt_q;
  logic [15:0]   nxt;

  assign nxt     = run_next(16'(cnt_q), line_i, clr_i, 16'(RUN_MIN));
  assign reach_o = line_i && !clr_i && (cnt_q == CW'(RUN_MIN - 1));
  assign seen_o  = (cnt_q == CW'(RUN_MIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= nxt[CW-1:0];
  end

  assert_cnt_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(RUN_MIN));
  assert_low_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !line_i |=> !seen_o);
  assert_reach_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reach_o |=> seen_o);

endmodule

// File: rtl/bit_collector.sv
module bit_collector #(
  parameter int unsigned W = 16,
  localparam int unsigned BW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_i,
  input  logic         line_i,
  output logic [W-1:0] word_o,
  output logic         full_o
);
  import dbgsel_pkg::*;

  logic [W-1:0]  sr_q;
  logic [BW-1:0] bcnt_q;
  logic [63:0]   shifted;

  assign shifted = lsb_first_shift(64'(sr_q), line_i, W);
  assign word_o  = shifted[W-1:0];
  assign full_o  = shift_i && (bcnt_q == BW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      bcnt_q <= '0;
    end else if (shift_i) begin
      sr_q   <= shifted[W-1:0];
      bcnt_q <= full_o ? '0 : bcnt_q + BW'(1);
    end else begin
      bcnt_q <= '0;
    end
  end

  assert_idle_count_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_i |=> bcnt_q == '0);

endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic reach_i,
  input  logic full_i,
  input  logic match_i,
  output logic shift_o,
  output logic clr_o,
  output logic mode_o,
  output logic pulse_o
);
  import dbgsel_pkg::*;

  sel_state_t st_q, st_d;
  logic mode_q, pulse_q;
  logic commit;

  assign commit  = (st_q == ST_CONFIRM) && reach_i;
  assign shift_o = ((st_q == ST_ARMED) && !line_i) || (st_q == ST_COLLECT);
  assign clr_o   = full_i;
  assign mode_o  = mode_q;
  assign pulse_o = pulse_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_HUNT:    if (reach_i) st_d = ST_ARMED;
      ST_ARMED:   if (!line_i) st_d = ST_COLLECT;
      ST_COLLECT: if (full_i)  st_d = match_i ? ST_CONFIRM : ST_HUNT;
      ST_CONFIRM: begin
        if (!line_i)      st_d = ST_HUNT;
        else if (reach_i) st_d = ST_ARMED;
      end
      default:            st_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_HUNT;
      mode_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      pulse_q <= commit && !mode_q;
      if (commit) mode_q <= 1'b1;
    end
  end

  assert_pulse_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  assert_rise_pulses_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q) |-> pulse_q);
  assert_mode_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |=> mode_q);
  assert_pulse_after_confirm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(st_q == ST_CONFIRM));

endmodule

// File: rtl/dbg_wire_select.sv
module dbg_wire_select #(
  parameter int unsigned RESET_MIN   = 51,
  parameter int unsigned SEL_W       = 16,
  parameter logic [SEL_W-1:0] SEL_PAT     = 16'hE79E,
  parameter logic [SEL_W-1:0] SEL_PAT_OLD = 16'hEDB6,
  parameter bit          ACCEPT_OLD  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic serial_mode_o,
  output logic line_reset_o,
  output logic mode_pulse_o
);

  logic             reach_evt;
  logic             shift_en;
  logic             cnt_clr;
  logic             word_full;
  logic             word_match;
  logic [SEL_W-1:0] word;

  run_counter #(.RUN_MIN(RESET_MIN)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_i  (line_i),
    .clr_i   (cnt_clr),
    .reach_o (reach_evt),
    .seen_o  (line_reset_o)
  );

  bit_collector #(.W(SEL_W)) u_bits (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (shift_en),
    .line_i  (line_i),
    .word_o  (word),
    .full_o  (word_full)
  );

  generate
    if (ACCEPT_OLD) begin : g_two_words
      assign word_match = (word == SEL_PAT) || (word == SEL_PAT_OLD);
    end else begin : g_one_word
      assign word_match = (word == SEL_PAT);
    end
  endgenerate

  mode_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_i  (line_i),
    .reach_i (reach_evt),
    .full_i  (word_full),
    .match_i (word_match),
    .shift_o (shift_en),
    .clr_o   (cnt_clr),
    .mode_o  (serial_mode_o),
    .pulse_o (mode_pulse_o)
  );

  assert_switch_on_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(serial_mode_o) |-> line_reset_o);

endmodule

// File: tb/dbg_wire_select_tb.sv
`timescale 1ns/1ps
module dbg_wire_select_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b0;
  logic serial_mode, line_reset, mode_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  int pulses   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  dbg_wire_select u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_i        (line),
    .serial_mode_o (serial_mode),
    .line_reset_o  (line_reset),
    .mode_pulse_o  (mode_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    line = b;
    @(posedge clk);
    #1;
    if (mode_pulse) pulses++;
  endtask

  task automatic send_run(input logic b, input int n);
    for (int i = 0; i < n; i++) send_bit(b);
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 0; i < 16; i++) send_bit(w[i]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    line  = 1'b0;
    rst_n = 1'b0;
    #1;
    check(serial_mode == 1'b0, "R9 mode", serial_mode, 0);
    check(line_reset == 1'b0, "R9 flag", line_reset, 0);
    check(mode_pulse == 1'b0, "R9 pulse", mode_pulse, 0);
    @(negedge clk);
    rst_n = 1'b1;
    pulses = 0;
  endtask

  task automatic t_flag();
    send_run(1'b0, 20);
    send_run(1'b1, 50);
    check(line_reset == 1'b0, "R1 50 highs", line_reset, 0);
    send_bit(1'b1);
    check(line_reset == 1'b1, "R1 51 highs", line_reset, 1);
    send_bit(1'b0);
    check(line_reset == 1'b0, "R1 low clears", line_reset, 0);
  endtask

  task automatic t_exact50();
    send_run(1'b0, 20);
    pulses = 0;
    send_run(1'b1, 50);
    send_word(16'hE79E);
    send_run(1'b1, 60);
    check(serial_mode == 1'b0, "R4 mode", serial_mode, 0);
    check(pulses == 0, "R4 pulses", pulses, 0);
  endtask

  task automatic t_near_miss();
    send_run(1'b0, 20);
    pulses = 0;
    send_run(1'b1, 60);
    send_word(16'hE78E);
    send_run(1'b1, 60);
    check(serial_mode == 1'b0, "R5 mode", serial_mode, 0);
    check(pulses == 0, "R5 pulses", pulses, 0);
  endtask

  task automatic t_select_new();
    send_run(1'b0, 20);
    pulses = 0;
    send_run(1'b1, 60);
    send_word(16'hE79E);
    send_run(1'b1, 50);
    check(serial_mode == 1'b0, "R6 50 trailing", serial_mode, 0);
    check(mode_pulse == 1'b0, "R7 no early pulse", mode_pulse, 0);
    send_bit(1'b1);
    check(serial_mode == 1'b1, "R2 R6 mode set", serial_mode, 1);
    check(mode_pulse == 1'b1, "R7 pulse with change", mode_pulse, 1);
    send_bit(1'b1);
    check(mode_pulse == 1'b0, "R7 pulse one cycle", mode_pulse, 0);
    check(pulses == 1, "R7 pulse count", pulses, 1);
  endtask

  task automatic t_repeat();
    send_run(1'b0, 20);
    pulses = 0;
    send_run(1'b1, 60);
    send_word(16'hE79E);
    send_run(1'b1, 60);
    check(serial_mode == 1'b1, "R8 mode kept", serial_mode, 1);
    check(pulses == 0, "R8 no pulse", pulses, 0);
  endtask

  task automatic t_select_old();
    send_run(1'b0, 20);
    pulses = 0;
    send_run(1'b1, 60);
    send_word(16'hEDB6);
    send_run(1'b1, 51);
    check(serial_mode == 1'b1, "R3 old word", serial_mode, 1);
    check(pulses == 1, "R3 pulse count", pulses, 1);
  endtask

  initial begin
    do_reset();
    t_flag();
    t_exact50();
    t_near_miss();
    t_select_new();
    t_repeat();
    do_reset();
    t_select_old();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule